// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block sits beside a memory slave on an AHB-Lite style bus shared by two requesters. It watches every address phase: the address, the write flag, the exclusive flag, the requester ID, and an error flag from the address decoder. In the following cycle, which is the data phase, it returns an exclusive-okay flag and a write-commit enable for the memory array. The block keeps one reservation slot per requester ID. Each slot holds a valid bit and an address with the reservation mask applied. Exclusive loads set the slot. Exclusive stores consume it, and succeed only when the reservation still matches. Plain stores take reservations away from the other requesters.

A configuration write turns the monitor on or off. While the monitor is off, every error-free transfer reports exclusive-okay high, exclusive stores commit like plain ones, and the reservation state is frozen. The address-phase inputs are already qualified by the bus ready signal, so `ap_valid` marks an address phase that completes on that clock edge.

Top module: `excl_mon_top`

## Requirements
- R1: After the synchronous reset, both slots are invalid and the monitor is disabled. In an idle cycle after reset, `xok` is 1 and `commit_we` is 0.
- R2: With the monitor enabled, an error-free exclusive read returns `xok`=1 and `commit_we`=0. It marks its requester's slot valid at the masked address.
- R3: An error-free exclusive write succeeds when its own slot is valid and the stored address equals the masked request address. A successful write returns `xok`=1 and `commit_we`=1.
- R4: An exclusive write clears its own slot whether it succeeds or fails, so a repeat of the same exclusive write fails.
- R5: A successful exclusive write invalidates every other slot holding the same masked address. A slot holding a different address is left intact.
- R6: With the monitor enabled, a plain write returns `xok`=0 and `commit_we`=1. It invalidates other slots holding the same masked address and leaves its own slot valid. A plain read returns `xok`=0 and `commit_we`=0.
- R7: A failed exclusive write returns `xok`=0 and `commit_we`=0, so memory is not modified.
- R8: With the monitor disabled, any error-free transfer returns `xok`=1, and writes of either kind return `commit_we`=1. No slot changes while the monitor is disabled.
- R9: A transfer with `ap_err`=1 returns `xok`=0 and `commit_we`=0 and leaves every slot unchanged, whether the monitor is enabled or disabled.
- R10: In a cycle whose preceding edge carried no transfer, `xok` equals the inverse of the enable bit as it stood before that edge, and `commit_we` is 0.
- R11: The reservation compare uses the address ANDed with `RESV_MASK`. The default mask clears bits [1:0], so addresses in the same 4-byte word match and addresses in different words do not.
- R12: A configuration write (`cfg_wr`=1, new value on `cfg_en`) updates the enable bit at the clock edge where it appears. A transfer on that same edge still uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | New enable value (1 = monitor on) |
| ap_valid | input | 1 | Address phase completes this edge |
| ap_addr | input | AW | Transfer address |
| ap_write | input | 1 | 1 = write, 0 = read |
| ap_excl | input | 1 | Exclusive access flag |
| ap_id | input | IDW | Requester ID, which selects the reservation slot |
| ap_err | input | 1 | Decoder reports this transfer will error |
| xok | output | 1 | Exclusive-okay flag in the data phase |
| commit_we | output | 1 | Memory write enable in the data phase |

## Verification
The bench checks cross-requester invalidation in both forms: a successful exclusive store and a plain store. A design that skipped either would let a stale store from the other requester succeed. A design that cleared the writer's own slot on a plain store would wrongly fail that requester's later exclusive store. The bench places addresses on both sides of the word mask, so a design that compared unmasked addresses, or that ignored too many bits, gets the wrong result. Exclusive reads made while the monitor is disabled must leave no reservation behind. Errored transfers must neither report success nor disturb a reservation. A configuration write issued on the same edge as a transfer checks that the transfer is judged with the old enable value.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_XRD = 2'b10,
    ACC_XWR = 2'b11
  } acc_kind_t;

  function automatic acc_kind_t kind_of(input logic excl, input logic write);
    return acc_kind_t'({excl, write});
  endfunction

endpackage

// File: rtl/excl_slot.sv
module excl_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      addr_o <= addr_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end

  // R2: a set records the masked address and validates the slot
  assert_set_records_R2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (vld_o && addr_o == $past(addr_i)));

  // R4: a clear without a set drops the reservation
  assert_clr_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !vld_o);

endmodule

// File: rtl/excl_decide.sv
module excl_decide
  import excl_mon_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 1,
  parameter int NS  = 2
) (
  input  acc_kind_t              kind,
  input  logic [IDW-1:0]         id,
  input  logic [AW-1:0]          maddr,
  input  logic [NS-1:0]          slot_vld,
  input  logic [NS-1:0][AW-1:0]  slot_addr,
  output logic                   xsucc,
  output logic [NS-1:0]          set_vec,
  output logic [NS-1:0]          clr_vec
);

  logic [NS-1:0] own;
  logic [NS-1:0] hit;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign own[s] = (id == IDW'(s));
    assign hit[s] = slot_vld[s] && (slot_addr[s] == maddr);
  end

  always_comb begin
    xsucc   = 1'b0;
    set_vec = '0;
    clr_vec = '0;
    unique case (kind)
      ACC_XRD: begin
        xsucc   = 1'b1;
        set_vec = own;
      end
      ACC_XWR: begin
        xsucc   = |(own & hit);
        clr_vec = own | (xsucc ? (hit & ~own) : '0);
      end
      ACC_WR: begin
        clr_vec = hit & ~own;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int              AW        = 32,
  parameter int              IDW       = 1,
  parameter logic [AW-1:0]   RESV_MASK = ~(AW'(3))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_en,
  input  logic           ap_valid,
  input  logic [AW-1:0]  ap_addr,
  input  logic           ap_write,
  input  logic           ap_excl,
  input  logic [IDW-1:0] ap_id,
  input  logic           ap_err,
  output logic           xok,
  output logic           commit_we
);

  localparam int NS = 1 << IDW;

  logic                  en_q;
  logic [AW-1:0]         maddr;
  logic [NS-1:0]         slot_vld;
  logic [NS-1:0][AW-1:0] slot_addr;
  logic [NS-1:0]         set_vec, clr_vec;
  logic                  xsucc;
  logic                  upd;
  acc_kind_t             kind;

  assign maddr = ap_addr & RESV_MASK;
  assign kind  = kind_of(ap_excl, ap_write);
  assign upd   = ap_valid && en_q && !ap_err;

  excl_decide #(.AW(AW), .IDW(IDW), .NS(NS)) u_decide (
    .kind      (kind),
    .id        (ap_id),
    .maddr     (maddr),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .xsucc     (xsucc),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec)
  );

  for (genvar s = 0; s < NS; s++) begin : g_resv
    excl_slot #(.AW(AW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .set_i  (upd && set_vec[s]),
      .clr_i  (upd && clr_vec[s]),
      .addr_i (maddr),
      .vld_o  (slot_vld[s]),
      .addr_o (slot_addr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      xok       <= 1'b1;
      commit_we <= 1'b0;
    end else begin
      if (cfg_wr) en_q <= cfg_en;
      if (ap_valid) begin
        xok       <= !ap_err && (!en_q || xsucc);
        commit_we <= ap_write && !ap_err && !(en_q && ap_excl && !xsucc);
      end else begin
        xok       <= !en_q;
        commit_we <= 1'b0;
      end
    end
  end

  // R9: errored transfers never report success nor commit
  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && ap_err) |=> (!xok && !commit_we));

  // R10: idle data phase mirrors the inverted enable bit
  assert_idle_okay_R10: assert property (@(posedge clk) disable iff (rst)
    !ap_valid |=> (xok == !$past(en_q) && !commit_we));

  // R8: no reservation movement while disabled
  assert_frozen_off_R8: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && !en_q) |=> $stable(slot_vld));

  // R4: an exclusive write always consumes its own slot
  assert_own_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (upd && ap_excl && ap_write) |=> !slot_vld[$past(ap_id)]);

  // R7: enabled exclusive writes commit exactly when they succeed
  assert_fail_no_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (upd && ap_excl && ap_write) |=> (commit_we == xok));

endmodule

// File: tb/test_excl_mon_top.sv
module test_excl_mon_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int IDW = 1;

  logic           clk = 1'b0;
  logic           rst;
  logic           cfg_wr, cfg_en;
  logic           ap_valid, ap_write, ap_excl, ap_err;
  logic [AW-1:0]  ap_addr;
  logic [IDW-1:0] ap_id;
  logic           xok, commit_we;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_mon_top #(.AW(AW), .IDW(IDW)) i_excl_mon_top (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .ap_valid(ap_valid), .ap_addr(ap_addr), .ap_write(ap_write),
    .ap_excl(ap_excl), .ap_id(ap_id), .ap_err(ap_err),
    .xok(xok), .commit_we(commit_we)
  );

  task automatic check(input string req, input logic exp_ok, input logic exp_we);
    n_run++;
    if (xok !== exp_ok || commit_we !== exp_we) begin
      n_fail++;
      $display("FAIL %s: xok/commit_we got %b/%b expected %b/%b",
               req, xok, commit_we, exp_ok, exp_we);
    end
  endtask

  task automatic idle_inputs();
    ap_valid = 0; ap_write = 0; ap_excl = 0; ap_err = 0;
    ap_addr = '0; ap_id = '0; cfg_wr = 0; cfg_en = 0;
  endtask

  // one transfer, optional simultaneous config write, check data phase
  task automatic xfer(input string req, input logic [AW-1:0] a, input logic wr,
                      input logic ex, input logic [IDW-1:0] id, input logic er,
                      input logic exp_ok, input logic exp_we,
                      input logic do_cfg = 0, input logic cfg_val = 0);
    @(negedge clk);
    ap_valid = 1; ap_addr = a; ap_write = wr; ap_excl = ex; ap_id = id; ap_err = er;
    cfg_wr = do_cfg; cfg_en = cfg_val;
    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk);
    check(req, exp_ok, exp_we);
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    cfg_wr = 1; cfg_en = v;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic idle_check(input string req, input logic exp_ok);
    @(negedge clk);
    @(negedge clk);
    check(req, exp_ok, 1'b0);
  endtask

  task automatic t_reset();
    idle_check("R1 idle after reset", 1'b1);
  endtask

  task automatic t_disabled();
    xfer("R8 disabled xread", 32'h80, 0, 1, 0, 0, 1, 0);
    xfer("R8 disabled xwrite commits", 32'h80, 1, 1, 0, 0, 1, 1);
    xfer("R8 disabled plain read", 32'h84, 0, 0, 1, 0, 1, 0);
    set_enable(1);
    idle_check("R10 idle when enabled", 1'b0);
    xfer("R8 no reservation left by disabled xread", 32'h80, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    xfer("R2 xread", 32'h100, 0, 1, 0, 0, 1, 0);
    xfer("R3 R11 xwrite same word", 32'h102, 1, 1, 0, 0, 1, 1);
    xfer("R4 R7 repeat xwrite fails", 32'h100, 1, 1, 0, 0, 0, 0);
    xfer("R2 xread again", 32'h100, 0, 1, 0, 0, 1, 0);
    xfer("R11 R7 next word fails", 32'h104, 1, 1, 0, 0, 0, 0);
    xfer("R4 slot gone after failed xwrite", 32'h100, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_cross();
    xfer("R2 id0 xread", 32'h200, 0, 1, 0, 0, 1, 0);
    xfer("R2 id1 xread", 32'h200, 0, 1, 1, 0, 1, 0);
    xfer("R3 id1 wins", 32'h200, 1, 1, 1, 0, 1, 1);
    xfer("R5 id0 invalidated", 32'h200, 1, 1, 0, 0, 0, 0);
    xfer("R2 id0 other addr", 32'h300, 0, 1, 0, 0, 1, 0);
    xfer("R2 id1 other addr", 32'h400, 0, 1, 1, 0, 1, 0);
    xfer("R3 id1 success", 32'h400, 1, 1, 1, 0, 1, 1);
    xfer("R5 non-matching slot kept", 32'h300, 1, 1, 0, 0, 1, 1);
  endtask

  task automatic t_plain();
    xfer("R2 id0 xread", 32'h500, 0, 1, 0, 0, 1, 0);
    xfer("R2 id1 xread", 32'h500, 0, 1, 1, 0, 1, 0);
    xfer("R6 plain write id1", 32'h501, 1, 0, 1, 0, 0, 1);
    xfer("R6 plain read", 32'h500, 0, 0, 1, 0, 0, 0);
    xfer("R6 other slot cleared", 32'h500, 1, 1, 0, 0, 0, 0);
    xfer("R6 own slot kept", 32'h500, 1, 1, 1, 0, 1, 1);
  endtask

  task automatic t_err();
    xfer("R2 xread", 32'h600, 0, 1, 0, 0, 1, 0);
    xfer("R9 errored xwrite", 32'h600, 1, 1, 0, 1, 0, 0);
    xfer("R9 reservation survives error", 32'h600, 1, 1, 0, 0, 1, 1);
    xfer("R9 errored plain write", 32'h600, 1, 0, 1, 1, 0, 0);
  endtask

  task automatic t_toggle();
    xfer("R2 xread", 32'h700, 0, 1, 0, 0, 1, 0);
    set_enable(0);
    idle_check("R10 idle when disabled", 1'b1);
    xfer("R8 disabled plain write", 32'h700, 1, 0, 1, 0, 1, 1);
    xfer("R9 errored read disabled", 32'h700, 0, 0, 1, 1, 0, 0);
    xfer("R12 same-edge enable uses old", 32'h704, 1, 0, 1, 0, 1, 1, 1, 1);
    xfer("R12 enable active next", 32'h708, 1, 0, 1, 0, 0, 1);
    xfer("R8 reservation kept across disable", 32'h700, 1, 1, 0, 0, 1, 1);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_disabled();
    t_basic();
    t_cross();
    t_plain();
    t_err();
    t_toggle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule